// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers single-cycle event pulses from a radio datapath into two 8-bit status registers, group A (packet and FIFO events) and group B (power, timer and receive-qualification events). Each group has its own enable mask. An event whose enable bit is set is latched into its status bit. The active-low interrupt request goes low while any latched bit has its enable bit set.

The host reaches the block through a small register port with a 3-bit select. Reading a status register returns its value and clears it at the clock edge that ends the read. A separate mirror view shows the packet outcome bits and three live activity states, and reading it clears nothing. The low-battery bit is a special case: it is recorded even while its enable bit is clear, so enabling it later raises the request. An option puts the request on the serial data-out line while chip select is high.

Top module: `evt_irq_hub`

## Requirements
- R1: After reset, both status registers and both enable masks read zero, and irq_n_o is high.
- R2: Group A bit positions: 0 CRC error, 1 packet valid, 2 packet sent, 3 external pin event, 4 RX almost full, 5 TX almost empty, 6 TX almost full, 7 FIFO over/underflow. A pulse on evt_a_i[k] with mask A bit k set makes status A bit k read 1 from the next cycle.
- R3: Group B bit positions: 0 power-on reset, 1 chip ready, 2 low battery, 3 wake-up timer, 4 RSSI over threshold, 5 invalid preamble, 6 valid preamble, 7 sync word. Latching follows the same rule as R2, using mask B.
- R4: An event whose mask bit is clear is not latched, except group B bit 2.
- R5: Group B bit 2 latches even when mask B bit 2 is clear. irq_n_o goes low the cycle after mask B bit 2 is written to 1.
- R6: irq_n_o is low exactly when some status bit and its mask bit are both 1.
- R7: rdata_o shows the register chosen by sel_i in the same cycle: 0 status A, 1 status B, 2 mask A, 3 mask B, 4 mirror, 5-7 zero. A cycle with rd_en_i=1 and sel_i 0 or 1 clears that status register at the clock edge.
- R8: An enabled event that coincides with a clearing read of its register stays set.
- R9: Mirror layout: bit 0 packet sent, bit 2 CRC error, bit 3 packet valid, copied from status A. Bits 6-7 are zero. Reading the mirror clears nothing.
- R10: Mirror bit 1 follows tx_busy_i, bit 4 follows rx_pkt_i and bit 5 follows pkt_hunt_i, all live.
- R11: sdo_o equals irq_n_o when route_irq_i=1 and csn_i=1; otherwise it equals sdo_data_i.
- R12: A write (wr_en_i=1) to sel 2 or 3 loads that mask from the next cycle. Writes to any other sel change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_a_i | input | 8 | Group A event pulses |
| evt_b_i | input | 8 | Group B event pulses |
| tx_busy_i | input | 1 | Live: transmitting |
| rx_pkt_i | input | 1 | Live: receiving a packet |
| pkt_hunt_i | input | 1 | Live: searching for a packet |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| sel_i | input | 3 | Register select |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data |
| csn_i | input | 1 | Serial chip select, active low |
| route_irq_i | input | 1 | Route request onto sdo_o |
| sdo_data_i | input | 1 | Serial data-out from the bus logic |
| sdo_o | output | 1 | Serial data-out pin |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is a clearing read that lands in the same cycle as an enabled event for the same register. The other hard case is a low-battery pulse that arrives while that bit is masked and is released only by a later mask write. The directed phases produce both on purpose: a read of status A carries a pulse on a chosen bit, and a masked low-battery pulse is followed by idle cycles and then a mask write. A long random phase then mixes reads, mask writes, routing and events, and a behavioural model is compared against the outputs every cycle.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int STAT_W = 8;
  localparam int SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_STAT_A = 3'd0,
    SEL_STAT_B = 3'd1,
    SEL_MASK_A = 3'd2,
    SEL_MASK_B = 3'd3,
    SEL_MIRROR = 3'd4
  } reg_sel_e;

  // Group A bit roles used by the mirror
  localparam int A_CRC_ERR = 0;
  localparam int A_PKT_OK  = 1;
  localparam int A_PKT_TX  = 2;
  // Group B bit that latches while masked
  localparam int B_LOW_BAT = 2;

  function automatic logic [STAT_W-1:0] stat_next(
    input logic [STAT_W-1:0] cur,
    input logic [STAT_W-1:0] evt,
    input logic [STAT_W-1:0] en,
    input logic [STAT_W-1:0] keep,
    input logic              clr
  );
    logic [STAT_W-1:0] base;
    base = clr ? '0 : cur;
    return base | (evt & (en | keep));
  endfunction

  function automatic logic any_pending(
    input logic [STAT_W-1:0] stat,
    input logic [STAT_W-1:0] en
  );
    return |(stat & en);
  endfunction

  function automatic logic [STAT_W-1:0] mirror_pack(
    input logic sent, input logic tx, input logic crc,
    input logic ok, input logic rx, input logic hunt
  );
    logic [STAT_W-1:0] m;
    m = '0;
    m[0] = sent;
    m[1] = tx;
    m[2] = crc;
    m[3] = ok;
    m[4] = rx;
    m[5] = hunt;
    return m;
  endfunction
endpackage

// File: rtl/evt_stat_bank.sv
module evt_stat_bank
  import evt_irq_pkg::*;
#(
  parameter int             W      = STAT_W,
  parameter logic [W-1:0]   STICKY = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] en_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] new_set_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] stat_d;

  always_comb begin
    stat_d    = stat_next(stat_q, evt_i, en_i, STICKY, clr_i);
    new_set_o = stat_d & ~stat_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/evt_host_port.sv
module evt_host_port
  import evt_irq_pkg::*;
#(
  parameter int W  = STAT_W,
  parameter int SW = SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [SW-1:0] sel_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  stat_a_i,
  input  logic [W-1:0]  stat_b_i,
  input  logic          tx_busy_i,
  input  logic          rx_pkt_i,
  input  logic          pkt_hunt_i,
  output logic [W-1:0]  mask_a_o,
  output logic [W-1:0]  mask_b_o,
  output logic          clr_a_o,
  output logic          clr_b_o,
  output logic          mirror_rd_o,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mask_a_q;
  logic [W-1:0] mask_b_q;
  logic [W-1:0] mirror;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_a_q <= '0;
      mask_b_q <= '0;
    end else if (wr_en_i) begin
      if (sel_i == SEL_MASK_A) mask_a_q <= wdata_i;
      if (sel_i == SEL_MASK_B) mask_b_q <= wdata_i;
    end
  end

  always_comb begin
    mirror = mirror_pack(stat_a_i[A_PKT_TX], tx_busy_i, stat_a_i[A_CRC_ERR],
                         stat_a_i[A_PKT_OK], rx_pkt_i, pkt_hunt_i);
    unique case (sel_i)
      SEL_STAT_A: rdata_o = stat_a_i;
      SEL_STAT_B: rdata_o = stat_b_i;
      SEL_MASK_A: rdata_o = mask_a_q;
      SEL_MASK_B: rdata_o = mask_b_q;
      SEL_MIRROR: rdata_o = mirror;
      default:    rdata_o = '0;
    endcase
  end

  assign clr_a_o     = rd_en_i && (sel_i == SEL_STAT_A);
  assign clr_b_o     = rd_en_i && (sel_i == SEL_STAT_B);
  assign mirror_rd_o = rd_en_i && (sel_i == SEL_MIRROR);
  assign mask_a_o    = mask_a_q;
  assign mask_b_o    = mask_b_q;
endmodule

// File: rtl/evt_irq_drive.sv
module evt_irq_drive
  import evt_irq_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic [W-1:0] stat_a_i,
  input  logic [W-1:0] stat_b_i,
  input  logic [W-1:0] mask_a_i,
  input  logic [W-1:0] mask_b_i,
  input  logic         route_irq_i,
  input  logic         csn_i,
  input  logic         sdo_data_i,
  output logic         irq_n_o,
  output logic         sdo_o
);
  logic pend;
  assign pend    = any_pending(stat_a_i, mask_a_i) | any_pending(stat_b_i, mask_b_i);
  assign irq_n_o = ~pend;
  assign sdo_o   = (route_irq_i && csn_i) ? irq_n_o : sdo_data_i;
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
  import evt_irq_pkg::*;
#(
  parameter int W  = STAT_W,
  parameter int SW = SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  evt_a_i,
  input  logic [W-1:0]  evt_b_i,
  input  logic          tx_busy_i,
  input  logic          rx_pkt_i,
  input  logic          pkt_hunt_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [SW-1:0] sel_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  input  logic          csn_i,
  input  logic          route_irq_i,
  input  logic          sdo_data_i,
  output logic          sdo_o,
  output logic          irq_n_o
);
  localparam int NBANK = 2;
  localparam logic [W-1:0] KEEP_B = W'(1) << B_LOW_BAT;

  logic [NBANK-1:0][W-1:0] evt_v;
  logic [NBANK-1:0][W-1:0] en_v;
  logic [NBANK-1:0][W-1:0] stat_v;
  logic [NBANK-1:0][W-1:0] new_set_v;
  logic [NBANK-1:0]        clr_v;

  logic [W-1:0] stat_a, stat_b, mask_a, mask_b;
  logic         clr_a, clr_b, mirror_rd;

  assign evt_v[0] = evt_a_i;
  assign evt_v[1] = evt_b_i;
  assign en_v[0]  = mask_a;
  assign en_v[1]  = mask_b;
  assign clr_v[0] = clr_a;
  assign clr_v[1] = clr_b;
  assign stat_a   = stat_v[0];
  assign stat_b   = stat_v[1];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    evt_stat_bank #(
      .W      (W),
      .STICKY ((g == 1) ? KEEP_B : '0)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_v[g]),
      .en_i      (en_v[g]),
      .clr_i     (clr_v[g]),
      .stat_o    (stat_v[g]),
      .new_set_o (new_set_v[g])
    );
  end

  evt_host_port #(.W(W), .SW(SW)) u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .sel_i       (sel_i),
    .wdata_i     (wdata_i),
    .stat_a_i    (stat_a),
    .stat_b_i    (stat_b),
    .tx_busy_i   (tx_busy_i),
    .rx_pkt_i    (rx_pkt_i),
    .pkt_hunt_i  (pkt_hunt_i),
    .mask_a_o    (mask_a),
    .mask_b_o    (mask_b),
    .clr_a_o     (clr_a),
    .clr_b_o     (clr_b),
    .mirror_rd_o (mirror_rd),
    .rdata_o     (rdata_o)
  );

  evt_irq_drive #(.W(W)) u_drive (
    .stat_a_i    (stat_a),
    .stat_b_i    (stat_b),
    .mask_a_i    (mask_a),
    .mask_b_i    (mask_b),
    .route_irq_i (route_irq_i),
    .csn_i       (csn_i),
    .sdo_data_i  (sdo_data_i),
    .irq_n_o     (irq_n_o),
    .sdo_o       (sdo_o)
  );
endmodule

// File: rtl/evt_irq_hub_chk.sv
module evt_irq_hub_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] evt_a,
  input logic [W-1:0] evt_b,
  input logic [W-1:0] stat_a,
  input logic [W-1:0] stat_b,
  input logic [W-1:0] mask_a,
  input logic [W-1:0] mask_b,
  input logic         clr_a,
  input logic         clr_b,
  input logic         mirror_rd,
  input logic         route,
  input logic         csn,
  input logic         sdo,
  input logic         irq_n
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_n && stat_a == '0 && stat_b == '0 && mask_a == '0 && mask_b == '0));

  assert_masked_a_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_a & ~$past(stat_a) & ~$past(mask_a)) == '0));

  assert_lowbat_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_b[2] |=> stat_b[2]);

  assert_irq_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_a & mask_a) != '0 || (stat_b & mask_b) != '0) |-> !irq_n);

  assert_clear_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_a |=> (stat_a == $past(evt_a & mask_a)));

  assert_clear_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_b |=> ((stat_b & ~$past(evt_b)) == '0));

  assert_mirror_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mirror_rd |=> ((stat_a & $past(stat_a)) == $past(stat_a)));

  assert_route_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (route && csn) |-> (sdo == irq_n));
endmodule

bind evt_irq_hub evt_irq_hub_chk #(.W(W)) u_chk (
  .clk       (clk_i),
  .rst_n     (rst_ni),
  .evt_a     (evt_a_i),
  .evt_b     (evt_b_i),
  .stat_a    (stat_a),
  .stat_b    (stat_b),
  .mask_a    (mask_a),
  .mask_b    (mask_b),
  .clr_a     (clr_a),
  .clr_b     (clr_b),
  .mirror_rd (mirror_rd),
  .route     (route_irq_i),
  .csn       (csn_i),
  .sdo       (sdo_o),
  .irq_n     (irq_n_o)
);

// File: tb/evt_irq_hub_bench.sv
`timescale 1ns/1ps
module evt_irq_hub_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_a = '0, evt_b = '0;
  logic       tx_busy = 0, rx_pkt = 0, pkt_hunt = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [2:0] sel = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       csn = 1, route = 0, sdo_data = 0;
  logic       sdo, irq_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural reference state
  int m_sa, m_sb, m_ma, m_mb;

  always #2 clk = ~clk;

  evt_irq_hub u_evt_irq_hub (
    .clk_i(clk), .rst_ni(rst_n), .evt_a_i(evt_a), .evt_b_i(evt_b),
    .tx_busy_i(tx_busy), .rx_pkt_i(rx_pkt), .pkt_hunt_i(pkt_hunt),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .sel_i(sel), .wdata_i(wdata),
    .rdata_o(rdata), .csn_i(csn), .route_irq_i(route),
    .sdo_data_i(sdo_data), .sdo_o(sdo), .irq_n_o(irq_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rdata();
    int m;
    case (sel)
      3'd0: return m_sa;
      3'd1: return m_sb;
      3'd2: return m_ma;
      3'd3: return m_mb;
      3'd4: begin
        m = 0;
        if (m_sa & 4) m += 1;
        if (tx_busy)  m += 2;
        if (m_sa & 1) m += 4;
        if (m_sa & 2) m += 8;
        if (rx_pkt)   m += 16;
        if (pkt_hunt) m += 32;
        return m;
      end
      default: return 0;
    endcase
  endfunction

  // inputs already applied after a negedge; compare, then advance model
  task automatic step();
    int ei, eq, sd;
    string rtag;
    #1;
    ei = ((m_sa & m_ma) != 0 || (m_sb & m_mb) != 0) ? 0 : 1;
    rtag = (sel == 4) ? "R9/R10 mirror" : (sel >= 2 && sel <= 3) ? "R12 mask read" : "R7 read";
    check(rtag, rdata, exp_rdata());
    check("R6 irq", irq_n, ei);
    sd = (route && csn) ? ei : sdo_data;
    check("R11 sdo", sdo, sd);
    @(posedge clk);
    eq = m_sa;
    if (rd_en && sel == 0) eq = 0;
    m_sa = eq | (evt_a & m_ma);
    eq = m_sb;
    if (rd_en && sel == 1) eq = 0;
    m_sb = eq | (evt_b & (m_mb | 4));
    if (wr_en && sel == 2) m_ma = wdata;
    if (wr_en && sel == 3) m_mb = wdata;
    @(negedge clk);
  endtask

  task automatic idle();
    evt_a = 0; evt_b = 0; wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    idle(); wr_en = 1; sel = s; wdata = d; step(); idle();
  endtask

  task automatic rd(input logic [2:0] s);
    idle(); rd_en = 1; sel = s; step(); idle();
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_sa = 0; m_sb = 0; m_ma = 0; m_mb = 0;
    repeat (3) @(negedge clk);
    // R1: reset state visible before release
    sel = 0; #1; check("R1 stat A", rdata, 0); check("R1 irq", irq_n, 1);
    rst_n = 1;
    @(negedge clk);
    for (int s = 0; s < 5; s++) begin sel = 3'(s); step(); end
    // R2: walk group A with full mask
    wr(2, 8'hFF);
    for (int k = 0; k < 8; k++) begin
      evt_a = 8'(1 << k); sel = 0; step(); idle();
      sel = 0; #1; check("R2 bit", rdata, 1 << k); #0;
      rd(0);
    end
    // R3: walk group B with full mask
    wr(3, 8'hFF);
    for (int k = 0; k < 8; k++) begin
      evt_b = 8'(1 << k); sel = 1; step(); idle();
      sel = 1; #1; check("R3 bit", rdata, 1 << k); #0;
      rd(1);
    end
    // R4/R5: masks cleared, events dropped except low battery
    wr(2, 8'h00); wr(3, 8'h00);
    evt_a = 8'hFF; evt_b = 8'hFF; sel = 0; step(); idle();
    sel = 0; #1; check("R4 A dropped", rdata, 0);
    sel = 1; #1; check("R5 lowbat kept", rdata, 8'h04);
    check("R5 irq still high", irq_n, 1);
    @(negedge clk);
    repeat (3) step();
    wr(3, 8'h04);
    #1; check("R5 irq after enable", irq_n, 0);
    @(negedge clk);
    rd(1);
    #1; check("R6 irq released", irq_n, 1);
    @(negedge clk);
    // R8: clearing read with coincident event
    wr(2, 8'hFF);
    evt_a = 8'h30; step(); idle();
    rd_en = 1; sel = 0; evt_a = 8'h02; step(); idle();
    sel = 0; #1; check("R8 event wins", rdata, 8'h02);
    @(negedge clk);
    // R9/R10: mirror, no clear
    evt_a = 8'h07; step(); idle();
    tx_busy = 1; rx_pkt = 0; pkt_hunt = 1;
    rd(4); rd(4);
    sel = 4; #1; check("R9 mirror", rdata, 8'h2F);
    sel = 0; #1; check("R9 no clear", rdata, 8'h07);
    @(negedge clk);
    tx_busy = 0; rx_pkt = 1; pkt_hunt = 0;
    rd(4);
    // R11: routing combos
    for (int c = 0; c < 8; c++) begin
      route = c[0]; csn = c[1]; sdo_data = c[2]; sel = 5; step();
    end
    // R12: writes to non-mask selects ignored
    wr(0, 8'h00); wr(1, 8'hFF); wr(4, 8'hFF); wr(7, 8'hAA);
    rd(2); rd(0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      evt_a = 8'($urandom) & 8'($urandom);
      evt_b = 8'($urandom) & 8'($urandom);
      rd_en = ($urandom % 3) == 0;
      wr_en = ($urandom % 5) == 0;
      sel = 3'($urandom);
      wdata = 8'($urandom);
      tx_busy = 1'($urandom); rx_pkt = 1'($urandom); pkt_hunt = 1'($urandom);
      route = 1'($urandom); csn = 1'($urandom); sdo_data = 1'($urandom);
      step();
    end
    idle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule